// File: doc/BRIEF.md
# Programmable Digital Ramp Generator

The block sweeps a 32-bit unsigned control word between a lower and an upper bound. It has separate increment and decrement step sizes, and a separate clock interval for each slope. A direction pin chooses between rising and falling. A hold pin freezes the sweep in place. Control bits enable the ramp, clear it, clear it on each register load, and select wrap-around ("no-dwell") behaviour at the bounds.

The bounds, step sizes and intervals are staged on configuration inputs. They are copied into the active set only on a load strobe, so software can prepare a new sweep without disturbing the one in progress.

The ramp value is steered to one of three synthesizer parameters: a 32-bit frequency word, a 16-bit phase word or a 12-bit amplitude word. It is aligned to the parameter's most significant bit. The other two parameters pass through from the active profile inputs.

The ramp output is a continuously held level rather than a stream of transfers. The block therefore has no valid/ready handshake and applies no back-pressure. A consumer samples the outputs on any clock.

Top module: `dsweep_gen`

## Requirements
- R1: After reset the ramp value is 0, the active bounds, steps and intervals are all 0, and the internal direction state is falling.
- R2: With direction 1, the ramp adds the active rising step once every N clocks, where N is the active rising interval.
- R3: With direction 0, the ramp subtracts the active falling step once every M clocks, where M is the active falling interval.
- R4: With no-dwell 0, a rising step that would pass the upper bound leaves the value at the upper bound. A falling step that would pass the lower bound (including unsigned underflow) leaves it at the lower bound.
- R5: With no-dwell 1, a rising step taken while the value is at or above the upper bound loads the lower bound. A falling step taken at or below the lower bound loads the upper bound.
- R6: A change of direction restarts the interval count with the new slope's interval and takes no step on that clock. The count also restarts each time a step is taken. An interval of 0 behaves as 1.
- R7: While hold is 1 the ramp value and the interval count do not change.
- R8: While enable is 0:
  - the ramp value and the interval count are frozen;
  - clear, autoclear, hold and direction have no effect;
  - all three parameter outputs equal their profile inputs.
- R9: While clear is 1 (and enable is 1) the ramp value is 0 on the next clock. When autoclear is 1, a load strobe sets the ramp value to 0. Clear takes priority over hold.
- R10: Configuration inputs reach the active set only on a clock where load is 1. Steps on that same clock still use the previous set.
- R11: Destination code 00 drives the frequency output with all 32 ramp bits. Code 01 drives the phase output with ramp bits [31:16]. Codes 10 and 11 drive the amplitude output with ramp bits [31:20]. Outputs that are not the destination equal their profile inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Ramp enable |
| nodwell_i | input | 1 | Wrap to the opposite bound at a limit |
| clr_i | input | 1 | Hold ramp value at zero |
| autoclr_i | input | 1 | Zero ramp value on each load strobe |
| load_i | input | 1 | Copy configuration inputs to active set |
| dir_i | input | 1 | 1 rising, 0 falling |
| hold_i | input | 1 | Freeze ramp and interval count |
| dest_i | input | 2 | Destination code |
| cfg_lo_i | input | 32 | Staged lower bound |
| cfg_hi_i | input | 32 | Staged upper bound |
| cfg_rise_step_i | input | 32 | Staged rising step |
| cfg_fall_step_i | input | 32 | Staged falling step |
| cfg_rise_rate_i | input | 16 | Staged rising interval in clocks |
| cfg_fall_rate_i | input | 16 | Staged falling interval in clocks |
| prof_freq_i | input | 32 | Profile frequency word |
| prof_phase_i | input | 16 | Profile phase word |
| prof_amp_i | input | 12 | Profile amplitude word |
| ramp_o | output | 32 | Current ramp value |
| freq_o | output | 32 | Frequency parameter out |
| phase_o | output | 16 | Phase parameter out |
| amp_o | output | 12 | Amplitude parameter out |

## Verification
The bench builds the block with its default widths: a 32-bit ramp, 16-bit intervals, and 16-bit phase and 12-bit amplitude parameters. Under these defaults the phase and amplitude slices are the true upper-bit alignments of a full-width word.

The bench keeps random intervals between 0 and 5 clocks. That puts many step expiries, direction reversals inside an interval, and interval-zero cases within a few thousand clocks.

The random bounds and steps are 32-bit. Steps that exceed the current value exercise unsigned underflow and overflow at both limits, with and without wrap-around.

// File: rtl/dsweep_pkg.sv
package dsweep_pkg;

  typedef enum logic [1:0] {
    TGT_FREQ  = 2'd0,
    TGT_PHASE = 2'd1,
    TGT_AMP   = 2'd2
  } tgt_e;

  // Upper code bit selects amplitude; lower bit only matters when it is clear.
  function automatic tgt_e decode_tgt(input logic [1:0] code);
    if (code[1])      return TGT_AMP;
    else if (code[0]) return TGT_PHASE;
    else              return TGT_FREQ;
  endfunction

endpackage

// File: rtl/dsweep_regs.sv
module dsweep_regs #(
  parameter int W  = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  cfg_lo_i,
  input  logic [W-1:0]  cfg_hi_i,
  input  logic [W-1:0]  cfg_rise_step_i,
  input  logic [W-1:0]  cfg_fall_step_i,
  input  logic [RW-1:0] cfg_rise_rate_i,
  input  logic [RW-1:0] cfg_fall_rate_i,
  output logic [W-1:0]  lo_q,
  output logic [W-1:0]  hi_q,
  output logic [W-1:0]  rise_step_q,
  output logic [W-1:0]  fall_step_q,
  output logic [RW-1:0] rise_rate_q,
  output logic [RW-1:0] fall_rate_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q        <= '0;
      hi_q        <= '0;
      rise_step_q <= '0;
      fall_step_q <= '0;
      rise_rate_q <= '0;
      fall_rate_q <= '0;
    end else if (load_i) begin
      lo_q        <= cfg_lo_i;
      hi_q        <= cfg_hi_i;
      rise_step_q <= cfg_rise_step_i;
      fall_step_q <= cfg_fall_step_i;
      rise_rate_q <= cfg_rise_rate_i;
      fall_rate_q <= cfg_fall_rate_i;
    end
  end

  // R10: active bounds move only on a load strobe
  p_cfg_only_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(rise_rate_q)));

endmodule

// File: rtl/dsweep_timer.sv
module dsweep_timer #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          hold_i,
  input  logic          dir_i,
  input  logic [RW-1:0] rise_rate_i,
  input  logic [RW-1:0] fall_rate_i,
  output logic          step_o
);

  logic [RW-1:0] cnt_q;
  logic          dir_q;
  logic          run;
  logic          turn;
  logic [RW-1:0] sel_rate;
  logic [RW-1:0] reload;

  assign run      = en_i && !hold_i;
  assign turn     = dir_i != dir_q;
  assign sel_rate = dir_i ? rise_rate_i : fall_rate_i;
  // A zero interval behaves as one: reload to zero means a step every clock.
  assign reload   = (sel_rate == '0) ? '0 : sel_rate - 1'b1;
  assign step_o   = run && !turn && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (run) begin
      dir_q <= dir_i;
      if (turn || cnt_q == '0) cnt_q <= reload;
      else                     cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: after a step with an interval above one, the next clock takes no step
  p_step_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && ((dir_q ? rise_rate_i : fall_rate_i) > 1)) |=> !step_o);

  // R7: hold freezes the interval count
  p_hold_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && hold_i) |=> $stable(cnt_q));

  // R6: a reversal never steps
  p_turn_nostep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && turn) |-> !step_o);

endmodule

// File: rtl/dsweep_accum.sv
module dsweep_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         autoclr_i,
  input  logic         load_i,
  input  logic         hold_i,
  input  logic         nodwell_i,
  input  logic         dir_i,
  input  logic         step_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] rise_step_i,
  input  logic [W-1:0] fall_step_i,
  output logic [W-1:0] acc_o
);

  logic [W-1:0] acc_q;
  logic [W:0]   sum_ext;
  logic [W:0]   dif_ext;
  logic [W-1:0] rise_nxt;
  logic [W-1:0] fall_nxt;
  logic         zero_now;

  assign sum_ext  = {1'b0, acc_q} + {1'b0, rise_step_i};
  assign dif_ext  = {1'b0, acc_q} - {1'b0, fall_step_i};
  assign zero_now = clr_i || (load_i && autoclr_i);

  always_comb begin
    if (acc_q >= hi_i)                    rise_nxt = nodwell_i ? lo_i : hi_i;
    else if (sum_ext > {1'b0, hi_i})      rise_nxt = hi_i;
    else                                  rise_nxt = sum_ext[W-1:0];
  end

  always_comb begin
    if (acc_q <= lo_i)                          fall_nxt = nodwell_i ? hi_i : lo_i;
    else if (dif_ext[W] || dif_ext[W-1:0] < lo_i) fall_nxt = lo_i;
    else                                        fall_nxt = dif_ext[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  acc_q <= '0;
    else if (en_i) begin
      if (zero_now)              acc_q <= '0;
      else if (!hold_i && step_i) acc_q <= dir_i ? rise_nxt : fall_nxt;
    end
  end

  assign acc_o = acc_q;

  // R9: clear wins over everything once enabled
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clr_i) |=> (acc_q == '0));

  // R7: hold keeps the value when no clear is pending
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && hold_i && !zero_now) |=> $stable(acc_q));

  // R8: disabled ramp keeps its value
  p_off_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(acc_q));

  // R4: saturating rise never passes the upper bound
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i && !hold_i && dir_i && !nodwell_i && !zero_now)
      |=> (acc_q <= $past(hi_i)));

  // R2: a rise from inside the bounds without wrap never decreases
  p_rise_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i && !hold_i && dir_i && !nodwell_i && !zero_now && acc_q <= hi_i)
      |=> (acc_q >= $past(acc_q)));

  // R3: a fall from inside the bounds without wrap never increases
  p_fall_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i && !hold_i && !dir_i && !nodwell_i && !zero_now && acc_q >= lo_i)
      |=> (acc_q <= $past(acc_q)));

endmodule

// File: rtl/dsweep_route.sv
module dsweep_route
  import dsweep_pkg::*;
#(
  parameter int W  = 32,
  parameter int PW = 16,
  parameter int AW = 12
) (
  input  logic          en_i,
  input  logic [1:0]    dest_i,
  input  logic [W-1:0]  ramp_i,
  input  logic [W-1:0]  prof_freq_i,
  input  logic [PW-1:0] prof_phase_i,
  input  logic [AW-1:0] prof_amp_i,
  output logic [W-1:0]  freq_o,
  output logic [PW-1:0] phase_o,
  output logic [AW-1:0] amp_o
);

  tgt_e tgt;
  assign tgt = decode_tgt(dest_i);

  always_comb begin
    freq_o  = prof_freq_i;
    phase_o = prof_phase_i;
    amp_o   = prof_amp_i;
    if (en_i) begin
      unique case (tgt)
        TGT_FREQ:  freq_o  = ramp_i;
        TGT_PHASE: phase_o = ramp_i[W-1 -: PW];
        default:   amp_o   = ramp_i[W-1 -: AW];
      endcase
    end
  end

  // R11: at most one parameter departs from its profile value
  always_comb begin
    a_one_target_r11: assert ($countones({freq_o != prof_freq_i,
                                          phase_o != prof_phase_i,
                                          amp_o != prof_amp_i}) <= 1);
  end

endmodule

// File: rtl/dsweep_gen.sv
module dsweep_gen #(
  parameter int W  = 32,
  parameter int RW = 16,
  parameter int PW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          nodwell_i,
  input  logic          clr_i,
  input  logic          autoclr_i,
  input  logic          load_i,
  input  logic          dir_i,
  input  logic          hold_i,
  input  logic [1:0]    dest_i,
  input  logic [W-1:0]  cfg_lo_i,
  input  logic [W-1:0]  cfg_hi_i,
  input  logic [W-1:0]  cfg_rise_step_i,
  input  logic [W-1:0]  cfg_fall_step_i,
  input  logic [RW-1:0] cfg_rise_rate_i,
  input  logic [RW-1:0] cfg_fall_rate_i,
  input  logic [W-1:0]  prof_freq_i,
  input  logic [PW-1:0] prof_phase_i,
  input  logic [AW-1:0] prof_amp_i,
  output logic [W-1:0]  ramp_o,
  output logic [W-1:0]  freq_o,
  output logic [PW-1:0] phase_o,
  output logic [AW-1:0] amp_o
);

  logic [W-1:0]  lo_q, hi_q, rise_step_q, fall_step_q;
  logic [RW-1:0] rise_rate_q, fall_rate_q;
  logic          step;

  dsweep_regs #(.W(W), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .cfg_lo_i(cfg_lo_i), .cfg_hi_i(cfg_hi_i),
    .cfg_rise_step_i(cfg_rise_step_i), .cfg_fall_step_i(cfg_fall_step_i),
    .cfg_rise_rate_i(cfg_rise_rate_i), .cfg_fall_rate_i(cfg_fall_rate_i),
    .lo_q(lo_q), .hi_q(hi_q), .rise_step_q(rise_step_q),
    .fall_step_q(fall_step_q), .rise_rate_q(rise_rate_q),
    .fall_rate_q(fall_rate_q)
  );

  dsweep_timer #(.RW(RW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .hold_i(hold_i), .dir_i(dir_i),
    .rise_rate_i(rise_rate_q), .fall_rate_i(fall_rate_q), .step_o(step)
  );

  dsweep_accum #(.W(W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i),
    .autoclr_i(autoclr_i), .load_i(load_i), .hold_i(hold_i),
    .nodwell_i(nodwell_i), .dir_i(dir_i), .step_i(step),
    .lo_i(lo_q), .hi_i(hi_q), .rise_step_i(rise_step_q),
    .fall_step_i(fall_step_q), .acc_o(ramp_o)
  );

  dsweep_route #(.W(W), .PW(PW), .AW(AW)) u_route (
    .en_i(en_i), .dest_i(dest_i), .ramp_i(ramp_o),
    .prof_freq_i(prof_freq_i), .prof_phase_i(prof_phase_i),
    .prof_amp_i(prof_amp_i), .freq_o(freq_o), .phase_o(phase_o),
    .amp_o(amp_o)
  );

  // R8: a disabled block hands every profile word straight through
  p_off_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (freq_o == prof_freq_i && phase_o == prof_phase_i && amp_o == prof_amp_i));

endmodule

// File: tb/dsweep_gen_tb.sv
module dsweep_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 0, nodwell_i = 0, clr_i = 0, autoclr_i = 0, load_i = 0;
  logic        dir_i = 0, hold_i = 0;
  logic [1:0]  dest_i = 0;
  logic [31:0] cfg_lo_i = 0, cfg_hi_i = 0, cfg_rise_step_i = 0, cfg_fall_step_i = 0;
  logic [15:0] cfg_rise_rate_i = 0, cfg_fall_rate_i = 0;
  logic [31:0] prof_freq_i = 32'h1234_5678;
  logic [15:0] prof_phase_i = 16'hABCD;
  logic [11:0] prof_amp_i = 12'h5A5;
  logic [31:0] ramp_o, freq_o;
  logic [15:0] phase_o;
  logic [11:0] amp_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_lo = 0, m_hi = 0, m_rs = 0, m_fs = 0, m_acc = 0;
  logic [15:0] m_rr = 0, m_fr = 0, m_cnt = 0;
  logic        m_dq = 0;

  always #2.5 clk = ~clk;

  dsweep_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .nodwell_i(nodwell_i),
    .clr_i(clr_i), .autoclr_i(autoclr_i), .load_i(load_i), .dir_i(dir_i),
    .hold_i(hold_i), .dest_i(dest_i), .cfg_lo_i(cfg_lo_i), .cfg_hi_i(cfg_hi_i),
    .cfg_rise_step_i(cfg_rise_step_i), .cfg_fall_step_i(cfg_fall_step_i),
    .cfg_rise_rate_i(cfg_rise_rate_i), .cfg_fall_rate_i(cfg_fall_rate_i),
    .prof_freq_i(prof_freq_i), .prof_phase_i(prof_phase_i),
    .prof_amp_i(prof_amp_i), .ramp_o(ramp_o), .freq_o(freq_o),
    .phase_o(phase_o), .amp_o(amp_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] reload(input logic [15:0] r);
    return (r == 0) ? 16'd0 : r - 16'd1;
  endfunction

  function automatic logic [31:0] rise_val(input logic [31:0] a);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, m_rs};
    if (a >= m_hi) return nodwell_i ? m_lo : m_hi;
    if (s > {1'b0, m_hi}) return m_hi;
    return s[31:0];
  endfunction

  function automatic logic [31:0] fall_val(input logic [31:0] a);
    if (a <= m_lo) return nodwell_i ? m_hi : m_lo;
    if (m_fs > a || (a - m_fs) < m_lo) return m_lo;
    return a - m_fs;
  endfunction

  // advance the reference by one clock using the inputs currently applied
  task automatic m_update();
    logic step;
    logic [31:0] nacc;
    step = en_i && !hold_i && (dir_i == m_dq) && (m_cnt == 0);
    nacc = m_acc;
    if (en_i) begin
      if (clr_i || (load_i && autoclr_i)) nacc = 0;
      else if (step) nacc = dir_i ? rise_val(m_acc) : fall_val(m_acc);
    end
    if (en_i && !hold_i) begin
      if (dir_i != m_dq || m_cnt == 0) m_cnt = reload(dir_i ? m_rr : m_fr);
      else m_cnt = m_cnt - 1;
      m_dq = dir_i;
    end
    m_acc = nacc;
    if (load_i) begin
      m_lo = cfg_lo_i; m_hi = cfg_hi_i; m_rs = cfg_rise_step_i;
      m_fs = cfg_fall_step_i; m_rr = cfg_rise_rate_i; m_fr = cfg_fall_rate_i;
    end
  endtask

  task automatic check_outs(input string req);
    logic [31:0] ef; logic [15:0] ep; logic [11:0] ea;
    string rt;
    ef = prof_freq_i; ep = prof_phase_i; ea = prof_amp_i;
    rt = en_i ? "R11" : "R8";
    if (en_i) begin
      if (dest_i[1]) ea = m_acc[31:20];
      else if (dest_i[0]) ep = m_acc[31:16];
      else ef = m_acc;
    end
    chk(req, ramp_o, m_acc);
    chk(rt, freq_o, ef);
    chk(rt, {16'd0, phase_o}, {16'd0, ep});
    chk(rt, {20'd0, amp_o}, {20'd0, ea});
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      m_update();
      @(negedge clk);
      load_i = 0;
      check_outs(req);
    end
  endtask

  task automatic load_cfg(input logic [31:0] lo, hi, rs, fs, input logic [15:0] rr, fr);
    cfg_lo_i = lo; cfg_hi_i = hi; cfg_rise_step_i = rs; cfg_fall_step_i = fs;
    cfg_rise_rate_i = rr; cfg_fall_rate_i = fr; load_i = 1;
    run(1, "R10");
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", ramp_o, 32'd0);                 // R1 reset value
    chk("R8", freq_o, prof_freq_i);           // disabled passthrough

    en_i = 1;
    // R2: rising every 3 clocks by 100, within bounds
    load_cfg(32'd100, 32'd1000, 32'd100, 32'd30, 16'd3, 16'd2);
    dir_i = 1;
    run(20, "R2");
    // R4: saturate at upper bound
    run(30, "R4");
    chk("R4", ramp_o, 32'd1000);
    // R3: falling by 30 every 2 clocks, saturate at lower
    dir_i = 0;
    run(80, "R3");
    chk("R4", ramp_o, 32'd100);
    // R5: wrap at the bounds
    nodwell_i = 1;
    run(40, "R5");
    dir_i = 1;
    run(40, "R5");
    nodwell_i = 0;
    // R6: interval zero acts as one, reversals
    load_cfg(32'd0, 32'hFFFF_FFFF, 32'd7, 32'd5, 16'd0, 16'd4);
    run(10, "R6");
    dir_i = 0; run(3, "R6"); dir_i = 1; run(3, "R6"); dir_i = 0; run(12, "R6");
    // R7: hold freezes value and count
    hold_i = 1; dir_i = 1; run(10, "R7"); hold_i = 0; run(6, "R7");
    // R8: disabled ignores clear and direction
    en_i = 0; clr_i = 1; dir_i = 0; run(5, "R8"); clr_i = 0; en_i = 1; run(4, "R8");
    // R9: clear over hold, autoclear on load
    hold_i = 1; clr_i = 1; run(3, "R9"); chk("R9", ramp_o, 32'd0);
    clr_i = 0; hold_i = 0; dir_i = 1; run(10, "R9");
    autoclr_i = 1; load_cfg(32'd0, 32'h00FF_0000, 32'h0001_0000, 32'd3, 16'd1, 16'd1);
    chk("R9", ramp_o, 32'd0); autoclr_i = 0;
    // R10: staged values without load are ignored
    cfg_hi_i = 32'd5; cfg_rise_step_i = 32'd1; cfg_rise_rate_i = 16'd9;
    run(20, "R10");
    // R11: each destination code
    for (int d = 0; d < 4; d++) begin
      dest_i = d[1:0];
      prof_freq_i = $urandom; prof_phase_i = 16'($urandom); prof_amp_i = 12'($urandom);
      run(4, "R11");
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) dir_i = ~dir_i;
      hold_i    = ($urandom_range(0, 9) == 0);
      clr_i     = ($urandom_range(0, 60) == 0);
      en_i      = ($urandom_range(0, 30) != 0);
      nodwell_i = ($urandom_range(0, 3) == 0);
      autoclr_i = ($urandom_range(0, 3) == 0);
      dest_i    = 2'($urandom);
      cfg_lo_i = $urandom; cfg_hi_i = $urandom;
      cfg_rise_step_i = $urandom >> $urandom_range(0, 31);
      cfg_fall_step_i = $urandom >> $urandom_range(0, 31);
      cfg_rise_rate_i = 16'($urandom_range(0, 5));
      cfg_fall_rate_i = 16'($urandom_range(0, 5));
      prof_freq_i = $urandom; prof_phase_i = 16'($urandom); prof_amp_i = 12'($urandom);
      load_i = ($urandom_range(0, 40) == 0);
      run(1, dir_i ? "R2" : "R3");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule